// File: doc/BRIEF.md
# Bus Grant Timeout Recovery

This block sits beside a bus arbiter and covers the case where a requester is granted the bus and never takes it. When the arbiter reports that it has issued a grant, the block starts a timer. If the bus-busy line is seen asserted before the timer expires, the grant was taken and the block goes back to rest. If the line stays low for the whole window, the block drives bus-busy itself for a fixed number of cycles and then lets it go. The arbiter then sees a normal busy-to-idle release and starts a new arbitration round among the requests still pending.

The timeout window is set in microseconds and converted to clock cycles from the clock frequency parameter. Its default of 410 µs is 82,000 cycles at 200 MHz. A single-bit enable register arms the recovery. The enable comes out of reset set. Writing zero to it drops the block to rest at once and removes any bus-busy the block is driving.

The controller has four states: `ST_IDLE` (waiting for a grant), `ST_ARMED` (the window is counting), `ST_FORCE` (the block drives bus-busy) and `ST_RELEASE` (the drive is off and the block waits for the line to read low). Its transitions are:

- **T_GRANT**: `ST_IDLE` to `ST_ARMED`.
- **T_TAKEN**: `ST_ARMED` to `ST_IDLE`, when the line is seen busy.
- **T_REGRANT**: `ST_ARMED` to `ST_ARMED`, which restarts the count.
- **T_EXPIRE**: `ST_ARMED` to `ST_FORCE`.
- **T_HELD**: `ST_FORCE` to `ST_RELEASE`.
- **T_QUIET**: `ST_RELEASE` to `ST_IDLE`.
- **T_DISABLE**: any state to `ST_IDLE`, when the enable is clear.

Top module: `bus_grant_watchdog`

## Requirements
- R1: After reset, `busy_drive` is 0, the controller is in `ST_IDLE`, and the enable register reads as 1, so recovery is armed without any write.
- R2: A grant pulse sampled at a clock edge while enabled and while `busy_line` is 0 starts the window. If `busy_line` stays 0 and no further grant arrives, `busy_drive` goes to 1 right after the edge that lies LIMIT_CYC edges after the grant edge. LIMIT_CYC = CLK_HZ × LIMIT_US / 1,000,000.
- R3: If `busy_line` is 1 at any edge inside the window, the window ends and `busy_drive` does not rise for that grant.
- R4: Once raised with the enable set, `busy_drive` stays at 1 for exactly HOLD_CYC cycles and then falls.
- R5: After the drive falls, the block accepts no new grant until `busy_line` has been sampled at 0. Grant pulses that arrive while the block is driving or releasing are ignored.
- R6: A grant pulse during the window restarts it. The drive then rises LIMIT_CYC edges after the latest grant edge.
- R7: While the enable register holds 0, `busy_drive` is 0 and grant pulses are ignored. Clearing the enable in the middle of a window or a drive removes the drive in the cycle after the write edge and abandons the count.
- R8: A write (`cfg_we` = 1) loads `cfg_en` into the enable register at the clock edge. The next grant after re-enabling starts a fresh, full-length window.
- R9: A grant pulse that arrives while `busy_line` is already 1 does not start a window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_en | input | 1 | Value written to the enable register |
| grant_pulse | input | 1 | One-cycle pulse from the arbiter when it issues a grant |
| busy_line | input | 1 | Sampled level of the shared bus-busy line (1 = busy) |
| busy_drive | output | 1 | 1 while this block pulls bus-busy on the requester's behalf |

## Verification
The bench aims at the exact edge where the window expires: a design that is off by one fires a cycle early or late, and the directed count exposes it. It tests a busy line that appears on the last cycle of the window, and a re-grant in mid-window. A design that misses either case fires a spurious drive. It also checks that the drive lasts exactly the hold length and is not shortened by the block's own reading of the line. Clearing the enable in mid-drive must cut the output at once, and grants that arrive while the line is busy or a release is pending must be ignored. A design that ignores these rules leaves a stuck or premature bus-busy that the reference model flags at once.

// File: rtl/bus_grant_watchdog_pkg.sv
package bus_grant_watchdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_FORCE   = 2'd2,
        ST_RELEASE = 2'd3
    } gw_state_t;

    function automatic int unsigned gw_cycles(input longint unsigned hz,
                                              input longint unsigned us);
        longint unsigned c;
        c = (hz * us) / 64'd1_000_000;
        if (c < 64'd2) c = 64'd2;
        return int'(c);
    endfunction

endpackage

// File: rtl/gw_enable_reg.sv
module gw_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    output logic en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else if (wr) begin
            en_q <= wdata;
        end
    end

    // R1: after reset the enable is observed set until a write clears it
    a_r1_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> $stable(en_q));

endmodule

// File: rtl/gw_span_counter.sv
module gw_span_counter #(
    parameter int unsigned SPAN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int unsigned W = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [W-1:0] LAST_V = W'(SPAN - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != LAST_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_V);

    // R2: the window count never passes its final value
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_V);

endmodule

// File: rtl/gw_ctrl_fsm.sv
module gw_ctrl_fsm
    import bus_grant_watchdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      grant,
    input  logic      busy_in,
    input  logic      wait_last,
    input  logic      hold_last,
    output logic      wait_clr,
    output logic      wait_inc,
    output logic      hold_clr,
    output logic      hold_inc,
    output gw_state_t state
);

    gw_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (en && grant && !busy_in) state_nxt = ST_ARMED;      // T_GRANT
            end
            ST_ARMED: begin
                if (!en)            state_nxt = ST_IDLE;                // T_DISABLE
                else if (busy_in)   state_nxt = ST_IDLE;                // T_TAKEN
                else if (grant)     state_nxt = ST_ARMED;               // T_REGRANT
                else if (wait_last) state_nxt = ST_FORCE;               // T_EXPIRE
            end
            ST_FORCE: begin
                if (!en)            state_nxt = ST_IDLE;                // T_DISABLE
                else if (hold_last) state_nxt = ST_RELEASE;             // T_HELD
            end
            ST_RELEASE: begin
                if (!en)            state_nxt = ST_IDLE;                // T_DISABLE
                else if (!busy_in)  state_nxt = ST_IDLE;                // T_QUIET
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wait_clr = 1'b0;
        wait_inc = 1'b0;
        hold_clr = 1'b1;
        hold_inc = 1'b0;
        unique case (state)
            ST_IDLE: begin
                wait_clr = 1'b1;
            end
            ST_ARMED: begin
                wait_clr = grant;
                wait_inc = !grant;
            end
            ST_FORCE: begin
                wait_clr = 1'b1;
                hold_clr = 1'b0;
                hold_inc = 1'b1;
            end
            ST_RELEASE: begin
                wait_clr = 1'b1;
            end
            default: begin
                wait_clr = 1'b1;
            end
        endcase
    end

    // R3: a busy line seen while armed never leads straight into forcing
    a_r3_taken_no_force: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && busy_in) |=> state != ST_FORCE);

    // R5: grants are not accepted from the release state
    a_r5_release_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE) |=> state != ST_ARMED);

    // R9: a grant that meets a busy line does not arm from rest
    a_r9_busy_grant_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && busy_in) |=> state == ST_IDLE);

endmodule

// File: rtl/bus_grant_watchdog.sv
module bus_grant_watchdog
    import bus_grant_watchdog_pkg::*;
#(
    parameter longint unsigned CLK_HZ   = 200_000_000,
    parameter longint unsigned LIMIT_US = 410,
    parameter int unsigned     HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_en,
    input  logic grant_pulse,
    input  logic busy_line,
    output logic busy_drive
);

    localparam int unsigned LIMIT_CYC = gw_cycles(CLK_HZ, LIMIT_US);
    localparam int unsigned HOLD_EFF  = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
    localparam int unsigned RUN_W     = $clog2(HOLD_EFF + 2);

    logic      en_q;
    logic      wait_clr, wait_inc, hold_clr, hold_inc;
    logic      wait_last, hold_last;
    gw_state_t state;

    gw_enable_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_we),
        .wdata (cfg_en),
        .en_q  (en_q)
    );

    gw_span_counter #(.SPAN(LIMIT_CYC)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .inc   (wait_inc),
        .last  (wait_last)
    );

    gw_span_counter #(.SPAN(HOLD_EFF)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_clr),
        .inc   (hold_inc),
        .last  (hold_last)
    );

    gw_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .grant     (grant_pulse),
        .busy_in   (busy_line),
        .wait_last (wait_last),
        .hold_last (hold_last),
        .wait_clr  (wait_clr),
        .wait_inc  (wait_inc),
        .hold_clr  (hold_clr),
        .hold_inc  (hold_inc),
        .state     (state)
    );

    assign busy_drive = (state == ST_FORCE) && en_q;

    // checker: length of the current self-driven run
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!busy_drive) begin
            run_len <= '0;
        end else if (run_len != {RUN_W{1'b1}}) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R4: a drive that ends while enabled lasted exactly the hold length
    a_r4_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_drive) && en_q && $past(en_q)) |-> run_len == RUN_W'(HOLD_EFF));

    // R2: the drive only begins out of an armed window
    a_r2_rise_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_drive) |-> $past(state) == ST_ARMED);

    // R7: a cleared enable brings the controller to rest
    a_r7_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q) |=> (state == ST_IDLE || en_q));

    // R5: the release state never drives the line
    a_r5_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE) |-> !busy_drive);

endmodule

// File: tb/bus_grant_watchdog_tb.sv
module bus_grant_watchdog_tb;

    localparam longint unsigned CLK_HZ   = 100_000;
    localparam longint unsigned LIMIT_US = 410;
    localparam int unsigned     HOLD     = 4;
    localparam int unsigned     LIM      = int'((CLK_HZ * LIMIT_US) / 64'd1_000_000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_en = 1'b0, grant_pulse = 1'b0, ext_busy = 1'b0;
    logic busy_drive;
    logic busy_line;

    assign busy_line = ext_busy | busy_drive;

    always #2.5 clk = ~clk;

    bus_grant_watchdog #(.CLK_HZ(CLK_HZ), .LIMIT_US(LIMIT_US), .HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
        .grant_pulse(grant_pulse), .busy_line(busy_line), .busy_drive(busy_drive)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // reference model, written from the requirements
    int m_st = 0;      // 0 rest, 1 armed, 2 forcing, 3 releasing
    int m_cnt = 0;
    int m_hold = 0;
    bit m_en = 1'b1;

    function automatic bit model_drive();
        return (m_st == 2) && m_en;
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: busy_drive=%0b expected %0b", req, cyc, act, exp);
        end
    endtask

    task automatic model_step(input bit g, input bit ext, input bit we, input bit wd);
        bit line;
        int st_n, cnt_n, hold_n;
        line = ext | model_drive();
        st_n = m_st; cnt_n = m_cnt; hold_n = m_hold;
        if (!m_en) begin
            st_n = 0;
        end else begin
            case (m_st)
                0: if (g && !line) begin st_n = 1; cnt_n = 0; end
                1: begin
                    if (line) st_n = 0;
                    else if (g) cnt_n = 0;
                    else if (m_cnt == LIM - 1) begin st_n = 2; hold_n = 0; end
                    else cnt_n = m_cnt + 1;
                end
                2: begin
                    if (m_hold == HOLD - 1) st_n = 3;
                    else hold_n = m_hold + 1;
                end
                default: if (!line) st_n = 0;
            endcase
        end
        m_st = st_n; m_cnt = cnt_n; m_hold = hold_n;
        if (we) m_en = wd;
    endtask

    function automatic string tag_of(input int st);
        case (st)
            0: return "R3";
            1: return "R2";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // one clock: drive at negedge, edge, then compare against the model
    task automatic cycle(input bit g, input bit ext, input bit we, input bit wd);
        @(negedge clk);
        grant_pulse = g; ext_busy = ext; cfg_we = we; cfg_en = wd;
        @(posedge clk);
        #1;
        model_step(g, ext, we, wd);
        cyc++;
        check(m_en ? tag_of(m_st) : "R7", busy_drive, model_drive());
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: run hung at cycle %0d expected completion", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ext_r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1", busy_drive, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // R2 + R1: exact expiry edge with the enable left at its reset value
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM - 1);
        check("R2", busy_drive, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);
        check("R2", busy_drive, 1'b1);
        // R4: held for HOLD cycles total, then released
        idle_n(HOLD - 1);
        check("R4", busy_drive, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);
        check("R4", busy_drive, 1'b0);
        idle_n(3);

        // R3: busy appears on the final cycle of the window
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM - 2);
        cycle(1'b0, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);
        idle_n(LIM + 2);
        check("R3", busy_drive, 1'b0);

        // R6: re-grant halfway restarts the window
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM / 2);
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM - 1);
        check("R6", busy_drive, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);
        check("R6", busy_drive, 1'b1);

        // R5: grant during forcing ignored; release waits for a quiet line
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(HOLD - 2);
        cycle(1'b0, 1'b1, 1'b0, 1'b0);
        check("R5", busy_drive, 1'b0);
        cycle(1'b1, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM + 2);
        check("R5", busy_drive, 1'b0);

        // R9: grant while line already busy
        cycle(1'b1, 1'b1, 1'b0, 1'b0);
        idle_n(LIM + 2);
        check("R9", busy_drive, 1'b0);

        // R7: clear enable mid-drive, drive drops next cycle; grants ignored
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM + 1);
        check("R7", busy_drive, 1'b1);
        cycle(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7", busy_drive, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM + 3);
        check("R7", busy_drive, 1'b0);

        // R8: re-enable, then a fresh full window
        cycle(1'b0, 1'b0, 1'b1, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 1'b0);
        idle_n(LIM - 1);
        check("R8", busy_drive, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", busy_drive, 1'b1);
        idle_n(HOLD + 2);

        // random phase against the model
        ext_r = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            bit g, we, wd;
            if (($urandom % 50) == 0) ext_r = ~ext_r;
            g  = (($urandom % 25) == 0);
            we = (($urandom % 400) == 0);
            wd = (($urandom % 4) != 0);
            cycle(g, ext_r, we, wd);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule